// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit turns one decoded memory operation into bus traffic and register side effects. It takes a base register value, a 12-bit unsigned immediate with a separate add/subtract sign, an addressing mode, an access size, a load/store direction and three register indices. It then checks whether the register combination is allowed. A legal operation issues one bus request, or two for a two-word access, on a valid/ready request port and waits for one response per request. The unit then reports completion together with the base-register writeback and any loaded data. When a word load targets the program counter, it also reports a branch target.

The unit accepts an operation while `op_ready` is high and works on that operation until it pulses `done`. Decode, the register file, condition evaluation and the memory itself sit outside the unit. Mode encoding: 0 = offset, 1 = pre-indexed, 2 = post-indexed, and 3 behaves as offset. Size encoding: 0 = byte, 1 = halfword, 2 = word, 3 = two-word. Register index 13 is the stack pointer and index 15 is the program counter.

Top module: `lsagu_top`

## Requirements
- R1: In offset mode (0) the request address is base plus the immediate (minus it when `op_sub`=1), and `wb_en` stays 0 at `done`.
- R2: In pre-indexed mode (1) the request address is base plus or minus the immediate, and at `done` `wb_en`=1 and `wb_value` equals that same address.
- R3: In post-indexed mode (2) the request address is the unmodified base, and at `done` `wb_en`=1 and `wb_value` is base plus or minus the immediate.
- R4: A two-word access (size 3) issues exactly two requests. The first goes to the computed address with `op_wdata`, and the second goes to that address plus 4 with `op_wdata2`. For a load, the first response appears on `ld_data` and the second on `ld_data2`.
- R5: These cases are illegal: a two-word load with `op_rt` equal to `op_rt2`, and a pre- or post-indexed operation whose `op_rn` equals `op_rt` (or `op_rt2` for two-word). An illegal operation raises `illegal` at `done`, issues no request, and leaves `wb_en` and `br_en` at 0.
- R6: A load with the program counter (15) or stack pointer (13) as a destination is legal only at word size. A store is illegal when the program counter is the data register or the base register. A store with the stack pointer as the data register is legal only at word size. Illegal cases behave as in R5.
- R7: A legal word load into register 15 asserts `br_en` at `done`. `br_target` is the loaded value with bit 0 cleared, and `br_err` is 1 exactly when bit 0 of the loaded value was 0.
- R8: Stores drive byte enables from size and address bits [1:0]. A byte store enables lane `addr[1:0]` and places the data byte in all four lanes. A halfword store enables lanes 1:0 when `addr[1]`=0, or lanes 3:2 when `addr[1]`=1, and places the low halfword in both halves. Word and two-word stores enable all lanes.
- R9: Byte and halfword loads return the addressed lane of the response, zero-extended to 32 bits, on `ld_data`.
- R10: `req_valid` and `req_addr` hold steady until `req_ready` is seen, and `op_ready` is low while an operation is in flight. `done` is a one-cycle pulse in the cycle after the last response is taken. For an illegal operation, it comes in the cycle after acceptance.
- R11: The immediate covers the full range 0 to 4095 in both add and subtract directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation taken when op_valid is high |
| op_load | input | 1 | 1 = load, 0 = store |
| op_mode | input | 2 | Addressing mode (0 offset, 1 pre, 2 post) |
| op_size | input | 2 | Access size (0 byte, 1 half, 2 word, 3 two-word) |
| op_sub | input | 1 | 1 = subtract immediate from base |
| op_rt | input | 4 | First transfer register index |
| op_rt2 | input | 4 | Second transfer register index (two-word only) |
| op_rn | input | 4 | Base register index |
| op_base | input | AW | Base register value |
| op_imm | input | IMMW | Unsigned immediate offset |
| op_wdata | input | 32 | Store data of first register |
| op_wdata2 | input | 32 | Store data of second register |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus request accepted |
| req_addr | output | AW | Bus request address |
| req_write | output | 1 | 1 = write request |
| req_be | output | 4 | Byte-lane enables |
| req_wdata | output | 32 | Write data on lanes |
| rsp_valid | input | 1 | Bus response valid |
| rsp_rdata | input | 32 | Bus response data |
| busy | output | 1 | Operation in flight |
| done | output | 1 | Operation complete (one cycle) |
| illegal | output | 1 | Register combination rejected |
| wb_en | output | 1 | Base writeback requested |
| wb_value | output | AW | New base value |
| ld_data | output | 32 | First loaded value |
| ld_data2 | output | 32 | Second loaded value |
| br_en | output | 1 | Program-counter load branches |
| br_target | output | 32 | Branch target, bit 0 clear |
| br_err | output | 1 | Loaded target had bit 0 clear |

## Verification
The first request appears one cycle after acceptance. Each response is absorbed on the edge it is presented, and `done` with its writeback, load and branch results follows one cycle after the last response, or one cycle after acceptance for a rejected operation. The bench drives inputs and samples outputs on falling edges. It records each request when it sees `req_valid`, holds `req_ready` for exactly one edge, and presents the response on the following falling edge. It reads the results only in the cycle where `done` is seen. This keeps every sample one half-cycle after the register that produced it.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;

    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;
    localparam int STEP    = LANES;

    typedef enum logic [1:0] {
        AM_OFFSET = 2'd0,
        AM_PRE    = 2'd1,
        AM_POST   = 2'd2,
        AM_RSVD   = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DUAL = 2'd3
    } asize_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_FIN
    } seq_state_e;

    // Lane enables for a request of a given size at a given low address.
    function automatic logic [LANES-1:0] lane_enables(asize_e sz, logic [1:0] lo);
        logic [LANES-1:0] be;
        case (sz)
            SZ_BYTE: be = 4'b0001 << lo;
            SZ_HALF: be = lo[1] ? 4'b1100 : 4'b0011;
            default: be = 4'b1111;
        endcase
        return be;
    endfunction

    // Replicate narrow store data onto every lane so any enabled lane carries it.
    function automatic logic [WORD_W-1:0] lane_spread(asize_e sz, logic [WORD_W-1:0] d);
        logic [WORD_W-1:0] r;
        case (sz)
            SZ_BYTE: r = {4{d[7:0]}};
            SZ_HALF: r = {2{d[15:0]}};
            default: r = d;
        endcase
        return r;
    endfunction

    // Pick the addressed lane of a response and zero-extend it.
    function automatic logic [WORD_W-1:0] lane_pick(asize_e sz, logic [1:0] lo, logic [WORD_W-1:0] d);
        logic [WORD_W-1:0] r;
        case (sz)
            SZ_BYTE: r = {24'd0, d[8*lo +: 8]};
            SZ_HALF: r = lo[1] ? {16'd0, d[31:16]} : {16'd0, d[15:0]};
            default: r = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lsagu_addr.sv
module lsagu_addr
    import lsagu_pkg::*;
#(
    parameter int AW   = 32,
    parameter int IMMW = 12
) (
    input  logic [AW-1:0]   base,
    input  logic [IMMW-1:0] imm,
    input  logic            sub,
    input  amode_e          mode,
    output logic [AW-1:0]   acc_addr,
    output logic            wb_en,
    output logic [AW-1:0]   wb_val
);
    localparam int PAD = AW - IMMW;

    logic [AW-1:0] ext_imm;
    logic [AW-1:0] moved;

    assign ext_imm = {{PAD{1'b0}}, imm};
    assign moved   = sub ? (base - ext_imm) : (base + ext_imm);

    always_comb begin
        acc_addr = moved;
        wb_en    = 1'b0;
        wb_val   = moved;
        case (mode)
            AM_PRE: begin
                wb_en = 1'b1;
            end
            AM_POST: begin
                acc_addr = base;
                wb_en    = 1'b1;
            end
            default: begin
                wb_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lsagu_legal.sv
module lsagu_legal
    import lsagu_pkg::*;
#(
    parameter int RW     = 4,
    parameter int PC_IDX = 15,
    parameter int SP_IDX = 13
) (
    input  logic          load,
    input  amode_e        mode,
    input  asize_e        size,
    input  logic [RW-1:0] rt,
    input  logic [RW-1:0] rt2,
    input  logic [RW-1:0] rn,
    output logic          illegal,
    output logic          pc_load
);
    localparam logic [RW-1:0] PC_R = RW'(PC_IDX);
    localparam logic [RW-1:0] SP_R = RW'(SP_IDX);

    logic dual, word, wb_form;
    logic rt_pc, rt_sp, rt2_pc, rt2_sp, rn_pc;
    logic overlap, pair_same;

    assign dual    = (size == SZ_DUAL);
    assign word    = (size == SZ_WORD);
    assign wb_form = (mode == AM_PRE) || (mode == AM_POST);
    assign rt_pc   = (rt == PC_R);
    assign rt_sp   = (rt == SP_R);
    assign rt2_pc  = dual && (rt2 == PC_R);
    assign rt2_sp  = dual && (rt2 == SP_R);
    assign rn_pc   = (rn == PC_R);
    assign overlap = wb_form && ((rn == rt) || (dual && (rn == rt2)));
    assign pair_same = dual && (rt == rt2);

    always_comb begin
        if (load) begin
            illegal = pair_same || overlap || rt2_pc || rt2_sp
                    || ((rt_pc || rt_sp) && !word);
        end else begin
            illegal = rt_pc || rt2_pc || rn_pc || rt2_sp || overlap
                    || (rt_sp && !word);
        end
    end

    assign pc_load = load && word && rt_pc;
endmodule

// File: rtl/lsagu_seq.sv
module lsagu_seq
    import lsagu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_fire,
    input  logic [AW-1:0]     in_addr,
    input  logic              in_wb_en,
    input  logic [AW-1:0]     in_wb_val,
    input  logic              in_ill,
    input  logic              in_load,
    input  asize_e            in_size,
    input  logic              in_pc_ld,
    input  logic [WORD_W-1:0] in_wd,
    input  logic [WORD_W-1:0] in_wd2,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [AW-1:0]     req_addr,
    output logic              req_write,
    output logic [LANES-1:0]  req_be,
    output logic [WORD_W-1:0] req_wdata,
    input  logic              rsp_valid,
    input  logic [WORD_W-1:0] rsp_rdata,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              wb_en,
    output logic [AW-1:0]     wb_value,
    output logic [WORD_W-1:0] ld_data,
    output logic [WORD_W-1:0] ld_data2,
    output logic              br_en,
    output logic [WORD_W-1:0] br_target,
    output logic              br_err
);
    seq_state_e        state;
    logic              beat;
    logic              load_q, ill_q, wb_en_q, pc_q;
    asize_e            size_q;
    logic [AW-1:0]     addr_q, wb_val_q;
    logic [WORD_W-1:0] wd_q, wd2_q, ld_q, ld2_q;
    logic              last_beat;

    assign last_beat = (size_q != SZ_DUAL) || beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            beat     <= 1'b0;
            load_q   <= 1'b0;
            ill_q    <= 1'b0;
            wb_en_q  <= 1'b0;
            pc_q     <= 1'b0;
            size_q   <= SZ_BYTE;
            addr_q   <= '0;
            wb_val_q <= '0;
            wd_q     <= '0;
            wd2_q    <= '0;
            ld_q     <= '0;
            ld2_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (op_fire) begin
                        beat     <= 1'b0;
                        load_q   <= in_load;
                        ill_q    <= in_ill;
                        wb_en_q  <= in_wb_en;
                        pc_q     <= in_pc_ld;
                        size_q   <= in_size;
                        addr_q   <= in_addr;
                        wb_val_q <= in_wb_val;
                        wd_q     <= in_wd;
                        wd2_q    <= in_wd2;
                        ld_q     <= '0;
                        ld2_q    <= '0;
                        state    <= in_ill ? ST_FIN : ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (req_ready) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (rsp_valid) begin
                        if (load_q) begin
                            if (beat) ld2_q <= rsp_rdata;
                            else      ld_q  <= lane_pick(size_q, addr_q[1:0], rsp_rdata);
                        end
                        if (last_beat) begin
                            state <= ST_FIN;
                        end else begin
                            beat  <= 1'b1;
                            state <= ST_REQ;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign req_valid = (state == ST_REQ);
    assign req_addr  = beat ? (addr_q + AW'(STEP)) : addr_q;
    assign req_write = !load_q;
    assign req_be    = lane_enables(size_q, addr_q[1:0]);
    assign req_wdata = beat ? wd2_q : lane_spread(size_q, wd_q);

    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_FIN);
    assign illegal   = done && ill_q;
    assign wb_en     = done && !ill_q && wb_en_q;
    assign wb_value  = wb_val_q;
    assign ld_data   = ld_q;
    assign ld_data2  = ld2_q;
    assign br_en     = done && !ill_q && pc_q;
    assign br_target = {ld_q[WORD_W-1:1], 1'b0};
    assign br_err    = br_en && !ld_q[0];
endmodule

// File: rtl/lsagu_top.sv
module lsagu_top
    import lsagu_pkg::*;
#(
    parameter int AW     = 32,
    parameter int IMMW   = 12,
    parameter int RW     = 4,
    parameter int PC_IDX = 15,
    parameter int SP_IDX = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic              op_load,
    input  logic [1:0]        op_mode,
    input  logic [1:0]        op_size,
    input  logic              op_sub,
    input  logic [RW-1:0]     op_rt,
    input  logic [RW-1:0]     op_rt2,
    input  logic [RW-1:0]     op_rn,
    input  logic [AW-1:0]     op_base,
    input  logic [IMMW-1:0]   op_imm,
    input  logic [31:0]       op_wdata,
    input  logic [31:0]       op_wdata2,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [AW-1:0]     req_addr,
    output logic              req_write,
    output logic [3:0]        req_be,
    output logic [31:0]       req_wdata,
    input  logic              rsp_valid,
    input  logic [31:0]       rsp_rdata,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              wb_en,
    output logic [AW-1:0]     wb_value,
    output logic [31:0]       ld_data,
    output logic [31:0]       ld_data2,
    output logic              br_en,
    output logic [31:0]       br_target,
    output logic              br_err
);
    amode_e        mode;
    asize_e        size;
    logic [AW-1:0] acc_addr, nxt_base;
    logic          nxt_wb, bad, pc_ld, fire;

    assign mode     = amode_e'(op_mode);
    assign size     = asize_e'(op_size);
    assign op_ready = !busy;
    assign fire     = op_valid && op_ready;

    lsagu_addr #(.AW(AW), .IMMW(IMMW)) u_addr (
        .base     (op_base),
        .imm      (op_imm),
        .sub      (op_sub),
        .mode     (mode),
        .acc_addr (acc_addr),
        .wb_en    (nxt_wb),
        .wb_val   (nxt_base)
    );

    lsagu_legal #(.RW(RW), .PC_IDX(PC_IDX), .SP_IDX(SP_IDX)) u_legal (
        .load    (op_load),
        .mode    (mode),
        .size    (size),
        .rt      (op_rt),
        .rt2     (op_rt2),
        .rn      (op_rn),
        .illegal (bad),
        .pc_load (pc_ld)
    );

    lsagu_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .op_fire   (fire),
        .in_addr   (acc_addr),
        .in_wb_en  (nxt_wb),
        .in_wb_val (nxt_base),
        .in_ill    (bad),
        .in_load   (op_load),
        .in_size   (size),
        .in_pc_ld  (pc_ld),
        .in_wd     (op_wdata),
        .in_wd2    (op_wdata2),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .busy      (busy),
        .done      (done),
        .illegal   (illegal),
        .wb_en     (wb_en),
        .wb_value  (wb_value),
        .ld_data   (ld_data),
        .ld_data2  (ld_data2),
        .br_en     (br_en),
        .br_target (br_target),
        .br_err    (br_err)
    );
endmodule

// File: rtl/lsagu_chk.sv
module lsagu_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          op_valid,
    input logic          op_ready,
    input logic [1:0]    op_mode,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          done,
    input logic          illegal,
    input logic          wb_en,
    input logic          br_en
);
    logic [1:0]    mode_q;
    logic [1:0]    hs_cnt;
    logic [AW-1:0] first_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= 2'd0;
            hs_cnt     <= 2'd0;
            first_addr <= '0;
        end else if (op_valid && op_ready) begin
            mode_q <= op_mode;
            hs_cnt <= 2'd0;
        end else if (req_valid && req_ready) begin
            if (hs_cnt == 2'd0) first_addr <= req_addr;
            if (hs_cnt != 2'd3) hs_cnt <= hs_cnt + 2'd1;
        end
    end

    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        op_ready |-> !req_valid && !done);

    p_offset_nowb_r1: assert property (@(posedge clk) disable iff (rst)
        done && (mode_q == 2'd0) |-> !wb_en);

    p_illegal_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        done && illegal |-> !wb_en && !br_en && (hs_cnt == 2'd0));

    p_second_addr_r4: assert property (@(posedge clk) disable iff (rst)
        req_valid && (hs_cnt == 2'd1) |-> req_addr == first_addr + AW'(4));

    p_at_most_two_r4: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> hs_cnt < 2'd2);
endmodule

bind lsagu_top lsagu_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_ready   (op_ready),
    .op_mode    (op_mode),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .done       (done),
    .illegal    (illegal),
    .wb_en      (wb_en),
    .br_en      (br_en)
);

// File: tb/tb_lsagu_top.sv
`timescale 1ns/1ps
module tb_lsagu_top;

    typedef struct packed {
        logic        ld;
        logic [1:0]  mode;
        logic [1:0]  size;
        logic        sub;
        logic [3:0]  rt;
        logic [3:0]  rt2;
        logic [3:0]  rn;
        logic [31:0] base;
        logic [11:0] imm;
        logic [31:0] wd;
        logic [31:0] wd2;
        logic [31:0] rd;
        logic        e_ill;
        logic [1:0]  e_n;
        logic [31:0] e_addr;
        logic [3:0]  e_be;
        logic [31:0] e_wd;
        logic        e_wben;
        logic [31:0] e_wb;
        logic [31:0] e_ld;
        logic        e_br;
    } vec_t;

    localparam int NV = 18;

    localparam vec_t VEC [NV] = '{
        '{1'b1,2'd0,2'd2,1'b0,4'd2,4'd0,4'd5,32'h1000,12'd960,32'h0,32'h0,32'hDEADBEEF,
          1'b0,2'd1,32'h13C0,4'hF,32'h0,1'b0,32'h0,32'hDEADBEEF,1'b0},
        '{1'b1,2'd1,2'd2,1'b0,4'd2,4'd0,4'd5,32'h1000,12'd960,32'h0,32'h0,32'h0BADF00D,
          1'b0,2'd1,32'h13C0,4'hF,32'h0,1'b1,32'h13C0,32'h0BADF00D,1'b0},
        '{1'b0,2'd2,2'd1,1'b0,4'd3,4'd0,4'd4,32'h2002,12'd4,32'h1234ABCD,32'h0,32'h0,
          1'b0,2'd1,32'h2002,4'hC,32'hABCDABCD,1'b1,32'h2006,32'h0,1'b0},
        '{1'b1,2'd0,2'd3,1'b0,4'd8,4'd9,4'd3,32'h0100,12'h020,32'h0,32'h0,32'h11112222,
          1'b0,2'd2,32'h0120,4'hF,32'h0,1'b0,32'h0,32'h11112222,1'b0},
        '{1'b0,2'd2,2'd3,1'b1,4'd0,4'd1,4'd8,32'h8000,12'd16,32'hA0A0A0A0,32'hB1B1B1B1,32'h0,
          1'b0,2'd2,32'h8000,4'hF,32'hA0A0A0A0,1'b1,32'h7FF0,32'h0,1'b0},
        '{1'b1,2'd0,2'd3,1'b0,4'd4,4'd4,4'd6,32'h0100,12'd0,32'h0,32'h0,32'h0,
          1'b1,2'd0,32'h0,4'h0,32'h0,1'b0,32'h0,32'h0,1'b0},
        '{1'b1,2'd1,2'd2,1'b0,4'd5,4'd0,4'd5,32'h0100,12'd8,32'h0,32'h0,32'h0,
          1'b1,2'd0,32'h0,4'h0,32'h0,1'b0,32'h0,32'h0,1'b0},
        '{1'b0,2'd2,2'd3,1'b0,4'd2,4'd3,4'd3,32'h0100,12'd8,32'h0,32'h0,32'h0,
          1'b1,2'd0,32'h0,4'h0,32'h0,1'b0,32'h0,32'h0,1'b0},
        '{1'b0,2'd0,2'd2,1'b0,4'd15,4'd0,4'd1,32'h0100,12'd0,32'h0,32'h0,32'h0,
          1'b1,2'd0,32'h0,4'h0,32'h0,1'b0,32'h0,32'h0,1'b0},
        '{1'b0,2'd0,2'd2,1'b0,4'd1,4'd0,4'd15,32'h0100,12'd0,32'h0,32'h0,32'h0,
          1'b1,2'd0,32'h0,4'h0,32'h0,1'b0,32'h0,32'h0,1'b0},
        '{1'b0,2'd0,2'd0,1'b0,4'd13,4'd0,4'd1,32'h0100,12'd0,32'h0,32'h0,32'h0,
          1'b1,2'd0,32'h0,4'h0,32'h0,1'b0,32'h0,32'h0,1'b0},
        '{1'b0,2'd0,2'd2,1'b0,4'd13,4'd0,4'd1,32'h0400,12'd0,32'h55AA55AA,32'h0,32'h0,
          1'b0,2'd1,32'h0400,4'hF,32'h55AA55AA,1'b0,32'h0,32'h0,1'b0},
        '{1'b1,2'd0,2'd0,1'b0,4'd13,4'd0,4'd1,32'h0100,12'd0,32'h0,32'h0,32'h0,
          1'b1,2'd0,32'h0,4'h0,32'h0,1'b0,32'h0,32'h0,1'b0},
        '{1'b1,2'd0,2'd0,1'b0,4'd6,4'd0,4'd1,32'h3001,12'd2,32'h0,32'h0,32'hAABBCCDD,
          1'b0,2'd1,32'h3003,4'h8,32'h0,1'b0,32'h0,32'h000000AA,1'b0},
        '{1'b1,2'd0,2'd1,1'b0,4'd6,4'd0,4'd1,32'h0010,12'd2,32'h0,32'h0,32'h87654321,
          1'b0,2'd1,32'h0012,4'hC,32'h0,1'b0,32'h0,32'h00008765,1'b0},
        '{1'b0,2'd0,2'd0,1'b0,4'd6,4'd0,4'd1,32'h0011,12'd0,32'h1234565E,32'h0,32'h0,
          1'b0,2'd1,32'h0011,4'h2,32'h5E5E5E5E,1'b0,32'h0,32'h0,1'b0},
        '{1'b1,2'd1,2'd2,1'b1,4'd1,4'd0,4'd2,32'h10000,12'hFFF,32'h0,32'h0,32'h600DCAFE,
          1'b0,2'd1,32'hF001,4'hF,32'h0,1'b1,32'hF001,32'h600DCAFE,1'b0},
        '{1'b1,2'd0,2'd2,1'b0,4'd15,4'd0,4'd1,32'h0200,12'd0,32'h0,32'h0,32'h00000801,
          1'b0,2'd1,32'h0200,4'hF,32'h0,1'b0,32'h0,32'h00000801,1'b1}
    };

    localparam string TAG [NV] = '{
        "R1", "R2", "R3 R8", "R4", "R4 R3", "R5", "R5", "R5",
        "R6", "R6", "R6", "R6", "R6", "R9", "R9", "R8", "R11 R2", "R7"
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        op_valid = 0, op_load = 0, op_sub = 0;
    logic [1:0]  op_mode = 0, op_size = 0;
    logic [3:0]  op_rt = 0, op_rt2 = 0, op_rn = 0;
    logic [31:0] op_base = 0, op_wdata = 0, op_wdata2 = 0;
    logic [11:0] op_imm = 0;
    logic        req_ready = 0, rsp_valid = 0;
    logic [31:0] rsp_rdata = 0;
    logic        op_ready, req_valid, req_write, busy, done, illegal, wb_en, br_en, br_err;
    logic [31:0] req_addr, req_wdata, wb_value, ld_data, ld_data2, br_target;
    logic [3:0]  req_be;

    lsagu_top dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
        .op_load(op_load), .op_mode(op_mode), .op_size(op_size), .op_sub(op_sub),
        .op_rt(op_rt), .op_rt2(op_rt2), .op_rn(op_rn), .op_base(op_base),
        .op_imm(op_imm), .op_wdata(op_wdata), .op_wdata2(op_wdata2),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy), .done(done),
        .illegal(illegal), .wb_en(wb_en), .wb_value(wb_value), .ld_data(ld_data),
        .ld_data2(ld_data2), .br_en(br_en), .br_target(br_target), .br_err(br_err)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int          n_req;
    bit          got;
    logic [31:0] c_addr [2];
    logic [31:0] c_wd [2];
    logic [3:0]  c_be;
    logic        c_wr, c_ill, c_wben, c_br, c_brerr;
    logic [31:0] c_wb, c_ld, c_ld2, c_brt;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input vec_t v, input int stall);
        @(negedge clk);
        op_load = v.ld; op_mode = v.mode; op_size = v.size; op_sub = v.sub;
        op_rt = v.rt; op_rt2 = v.rt2; op_rn = v.rn; op_base = v.base;
        op_imm = v.imm; op_wdata = v.wd; op_wdata2 = v.wd2;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        chk(op_ready == 1'b0, "R10 op_ready in flight", {31'd0, op_ready}, 32'd0);
        n_req = 0;
        got = 0;
        for (int k = 0; k < 40 && !got; k++) begin
            if (done) begin
                got = 1;
                c_ill = illegal; c_wben = wb_en; c_wb = wb_value;
                c_ld = ld_data; c_ld2 = ld_data2;
                c_br = br_en; c_brt = br_target; c_brerr = br_err;
            end else if (req_valid) begin
                if (n_req < 2) begin
                    c_addr[n_req] = req_addr;
                    c_wd[n_req] = req_wdata;
                end
                if (n_req == 0) begin
                    c_be = req_be;
                    c_wr = req_write;
                end
                for (int s = 0; s < stall && n_req == 0; s++) begin
                    @(negedge clk);
                    chk(req_valid && req_addr == c_addr[0], "R10 request held",
                        req_addr, c_addr[0]);
                end
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
                rsp_valid = 1'b1;
                rsp_rdata = (n_req == 0) ? v.rd : v.rd + 32'd1;
                n_req++;
                @(negedge clk);
                rsp_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(op_ready && !busy && !req_valid && !done, "R10 reset idle",
            {28'd0, op_ready, busy, req_valid, done}, 32'h8);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            run_op(v, 0);
            chk(got, TAG[i], {31'd0, got}, 32'd1);
            chk(c_ill == v.e_ill, TAG[i], {31'd0, c_ill}, {31'd0, v.e_ill});
            chk(n_req == int'(v.e_n), TAG[i], n_req, {30'd0, v.e_n});
            if (v.e_ill) begin
                chk(!c_wben && !c_br, "R5 illegal side effects", {30'd0, c_wben, c_br}, 32'd0);
            end
            if (v.e_n != 0) begin
                chk(c_addr[0] == v.e_addr, TAG[i], c_addr[0], v.e_addr);
                chk(c_be == v.e_be, TAG[i], {28'd0, c_be}, {28'd0, v.e_be});
                chk(c_wr == !v.ld, TAG[i], {31'd0, c_wr}, {31'd0, !v.ld});
                if (!v.ld) chk(c_wd[0] == v.e_wd, TAG[i], c_wd[0], v.e_wd);
                chk(c_wben == v.e_wben, TAG[i], {31'd0, c_wben}, {31'd0, v.e_wben});
                if (v.e_wben) chk(c_wb == v.e_wb, TAG[i], c_wb, v.e_wb);
                if (v.ld) chk(c_ld == v.e_ld, TAG[i], c_ld, v.e_ld);
                chk(c_br == v.e_br, TAG[i], {31'd0, c_br}, {31'd0, v.e_br});
                if (v.e_br) begin
                    chk(c_brt == (v.e_ld & ~32'd1), "R7 branch target", c_brt, v.e_ld & ~32'd1);
                    chk(!c_brerr, "R7 no error on odd target", {31'd0, c_brerr}, 32'd0);
                end
            end
            if (v.e_n == 2) begin
                chk(c_addr[1] == v.e_addr + 32'd4, "R4 second address", c_addr[1], v.e_addr + 32'd4);
                if (v.ld) chk(c_ld2 == v.rd + 32'd1, "R4 second load", c_ld2, v.rd + 32'd1);
                else      chk(c_wd[1] == v.wd2, "R4 second store data", c_wd[1], v.wd2);
            end
        end

        // R10: stalled request stays put, then completes
        begin
            vec_t v;
            v = VEC[11];
            run_op(v, 3);
            chk(got && n_req == 1 && c_addr[0] == 32'h400, "R10 stalled store",
                c_addr[0], 32'h400);
        end

        // R7: even target raises the error flag
        begin
            vec_t v;
            v = VEC[17];
            v.rd = 32'h0000_0800;
            run_op(v, 0);
            chk(c_br && c_brerr, "R7 even target error", {30'd0, c_br, c_brerr}, 32'd3);
            chk(c_brt == 32'h800, "R7 even target value", c_brt, 32'h800);
        end

        // R11: largest immediate added, offset mode
        begin
            vec_t v;
            v = VEC[0];
            v.imm = 12'hFFF;
            v.base = 32'h1;
            run_op(v, 0);
            chk(c_addr[0] == 32'h1000, "R11 max immediate add", c_addr[0], 32'h1000);
            chk(!c_wben, "R1 no writeback", {31'd0, c_wben}, 32'd0);
        end

        @(negedge clk);
        chk(op_ready && !done, "R10 back to idle", {30'd0, op_ready, done}, 32'd2);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule